// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block holds a 16-bit configuration word that sets the rotation sense, a ten-bit zero offset and four output-mode controls for the surrounding sensor logic. After any reset the word may be reloaded over a three-wire serial path. A load starts when the select line goes from low to high while the program-data line is high. The next sixteen rising edges of the serial clock each shift in one data bit. When the last bit arrives, every decoded field changes together in a single cycle. From then on the block ignores serial activity until it is reset again.

A separate burn step makes the loaded word permanent. The programming-level input is held high and sixteen serial-clock pulses are applied. If the level stays high for all sixteen pulses, the working word is copied into a shadow register, which is not cleared by a soft reset. The burned value therefore reaches the outputs only after the next soft reset, and a soft reset is also the only way out of a finished load. A full reset clears the shadow and the working word to all zero.

All inputs are taken as synchronous to the system clock. Edges on the select and serial-clock lines are found by comparing each input with its value in the previous cycle.

Top module: `cfg_loader`

## Requirements
- R1: After a full reset every output field is zero and `loading` is low.
- R2: A load starts only when `sel` goes from low to high while `pdata` is high. A rise of `sel` with `pdata` low starts nothing, and serial clocks that follow it leave the fields unchanged.
- R3: Each rising edge of `sclk` during a load shifts in one bit. The first bit sent becomes `dir_ccw`. The next ten bits become `zero_pos`, most significant bit first. Then come `fb_int_en`, `ref_ext_en` and `clamp_en`, and the last two bits are `out_span[1]` followed by `out_span[0]`.
- R4: The fields keep their old value until the sixteenth bit has arrived, and then all of them change in the same cycle.
- R5: Once sixteen bits have been taken, further `sclk` edges do not change any field.
- R6: After a completed load, a new start condition on `sel` and `pdata` is ignored until a reset.
- R7: A soft reset with no completed burn loads the working word from the shadow. The shadow is all zero after a full reset.
- R8: While `burn_lvl` stays high for sixteen `sclk` rises after a completed load, the working word is copied to the shadow. The outputs do not change until a soft reset, after which they show the burned word.
- R9: If `burn_lvl` drops before the sixteenth burn pulse, the pulse count restarts and the shadow keeps its old value.
- R10: A full reset clears the shadow, so a soft reset that follows it gives all-zero fields.
- R11: `loading` is high from the cycle after a valid start until the sixteenth bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| full_rst_n | input | 1 | Asynchronous active-low reset; clears the working word and the shadow |
| soft_rst_n | input | 1 | Synchronous active-low reset; reloads the working word from the shadow |
| sel | input | 1 | Select line; a rising edge with `pdata` high starts a load |
| sclk | input | 1 | Serial clock; its rising edges shift data bits in and count burn pulses |
| pdata | input | 1 | Serial program data |
| burn_lvl | input | 1 | Programming level; must stay high through all burn pulses |
| loading | output | 1 | High while a load is in progress |
| dir_ccw | output | 1 | Rotation sense field |
| zero_pos | output | 10 | Zero offset field |
| fb_int_en | output | 1 | Internal-feedback enable field |
| ref_ext_en | output | 1 | External-reference enable field |
| clamp_en | output | 1 | Output clamp enable field |
| out_span | output | 2 | Angular span select field |

## Verification
The hardest case to reach from the ports is a burn that is cut short. The only sign of the shadow is the output after a later soft reset, so an aborted burn can be seen only two steps later. The stimulus first burns a known word. It then loads a different word, raises `burn_lvl` for eight pulses, drops it, and raises it again for eight more pulses, so that sixteen pulses occur in total but no run of sixteen is unbroken. A soft reset must then bring back the first word. Randomly chosen words, with the burn done or skipped at random, check the shadow model again across repeated soft resets.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int CFG_W  = 16;
  localparam int ZERO_W = CFG_W - 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HELD  = 2'd2,
    ST_BURNT = 2'd3
  } ld_state_t;

  typedef struct packed {
    logic              ccw;
    logic [ZERO_W-1:0] zero;
    logic              fb_int;
    logic              ref_ext;
    logic              clamp;
    logic [1:0]        span;
  } cfg_fields_t;

  // First bit shifted in ends up at the top of the word.
  function automatic cfg_fields_t split_word(input logic [CFG_W-1:0] w);
    cfg_fields_t f;
    f.ccw     = w[CFG_W-1];
    f.zero    = w[CFG_W-2 -: ZERO_W];
    f.fb_int  = w[4];
    f.ref_ext = w[3];
    f.clamp   = w[2];
    f.span    = w[1:0];
    return f;
  endfunction

  function automatic logic [CFG_W-1:0] push_bit(input logic [CFG_W-1:0] w,
                                                input logic b);
    return {w[CFG_W-2:0], b};
  endfunction
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] d,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // Reset to one so that a line held high through reset gives no edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev[i] <= 1'b1;
      else if (clr) prev[i] <= 1'b1;
      else          prev[i] <= d[i];
    end
    assign rise[i] = d[i] & ~prev[i];
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_loader_pkg::*;
#(
  parameter int BURN_PULSES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             sel_rise,
  input  logic             clk_rise,
  input  logic             pdata,
  input  logic             burn_lvl,
  output logic             loading,
  output logic             word_load,
  output logic [CFG_W-1:0] load_word,
  output logic             burn_commit
);
  localparam int BIT_CW  = $clog2(CFG_W + 1);
  localparam int BURN_CW = $clog2(BURN_PULSES + 1);
  localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(CFG_W - 1);
  localparam logic [BURN_CW-1:0] LAST_BURN = BURN_CW'(BURN_PULSES - 1);

  ld_state_t          state;
  logic [CFG_W-1:0]   shreg;
  logic [BIT_CW-1:0]  bit_cnt;
  logic [BURN_CW-1:0] burn_cnt;

  assign loading     = (state == ST_SHIFT);
  assign word_load   = loading && clk_rise && (bit_cnt == LAST_BIT);
  assign load_word   = push_bit(shreg, pdata);
  assign burn_commit = (state == ST_HELD) && burn_lvl && clk_rise &&
                       (burn_cnt == LAST_BURN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_clr) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      burn_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (sel_rise && pdata) begin
          state   <= ST_SHIFT;
          bit_cnt <= '0;
        end
        ST_SHIFT: if (clk_rise) begin
          shreg   <= push_bit(shreg, pdata);
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) state <= ST_HELD;
        end
        ST_HELD: begin
          if (!burn_lvl) burn_cnt <= '0;
          else if (clk_rise) begin
            if (burn_cnt == LAST_BURN) begin
              state    <= ST_BURNT;
              burn_cnt <= '0;
            end else begin
              burn_cnt <= burn_cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BIT_CW'(CFG_W));

  // R6
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HELD) |=> (state != ST_SHIFT));

  // R2
  entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loading) |-> $past(sel_rise && pdata));

  // R9
  burn_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HELD && !burn_lvl) |=> (burn_cnt == '0));
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_loader_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             word_load,
  input  logic [CFG_W-1:0] load_word,
  input  logic             burn_commit,
  output logic [CFG_W-1:0] work
);
  logic [CFG_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work   <= '0;
      shadow <= '0;
    end else begin
      if (soft_clr)       work <= shadow;
      else if (word_load) work <= load_word;
      if (burn_commit && !soft_clr) shadow <= work;
    end
  end

  // R4
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !word_load) |=> $stable(work));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burn_commit |=> $stable(shadow));

  // R7
  soft_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (work == $past(shadow)));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int BURN_PULSES = 16
) (
  input  logic              clk,
  input  logic              full_rst_n,
  input  logic              soft_rst_n,
  input  logic              sel,
  input  logic              sclk,
  input  logic              pdata,
  input  logic              burn_lvl,
  output logic              loading,
  output logic              dir_ccw,
  output logic [ZERO_W-1:0] zero_pos,
  output logic              fb_int_en,
  output logic              ref_ext_en,
  output logic              clamp_en,
  output logic [1:0]        out_span
);
  logic             soft_clr;
  logic [1:0]       rises;
  logic             word_load;
  logic             burn_commit;
  logic [CFG_W-1:0] load_word;
  logic [CFG_W-1:0] work;
  cfg_fields_t      fields;

  assign soft_clr = !soft_rst_n;

  cfg_edge_det #(.N(2)) u_edges (
    .clk  (clk),
    .rst_n(full_rst_n),
    .clr  (soft_clr),
    .d    ({sclk, sel}),
    .rise (rises)
  );

  cfg_seq #(.BURN_PULSES(BURN_PULSES)) u_seq (
    .clk        (clk),
    .rst_n      (full_rst_n),
    .soft_clr   (soft_clr),
    .sel_rise   (rises[0]),
    .clk_rise   (rises[1]),
    .pdata      (pdata),
    .burn_lvl   (burn_lvl),
    .loading    (loading),
    .word_load  (word_load),
    .load_word  (load_word),
    .burn_commit(burn_commit)
  );

  cfg_store u_store (
    .clk        (clk),
    .rst_n      (full_rst_n),
    .soft_clr   (soft_clr),
    .word_load  (word_load),
    .load_word  (load_word),
    .burn_commit(burn_commit),
    .work       (work)
  );

  assign fields     = split_word(work);
  assign dir_ccw    = fields.ccw;
  assign zero_pos   = fields.zero;
  assign fb_int_en  = fields.fb_int;
  assign ref_ext_en = fields.ref_ext;
  assign clamp_en   = fields.clamp;
  assign out_span   = fields.span;

  // R1
  full_reset_chk: assert property (@(posedge clk)
    $rose(full_rst_n) |-> (work == '0 && !loading));
endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  logic clk = 1'b0;
  logic full_rst_n = 1'b0, soft_rst_n = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, pdata = 1'b0, burn_lvl = 1'b0;
  logic loading, dir_ccw, fb_int_en, ref_ext_en, clamp_en;
  logic [9:0] zero_pos;
  logic [1:0] out_span;

  int errors = 0, checks = 0;
  logic [15:0] exp_shadow = '0;

  always #4 clk = ~clk;

  cfg_loader dut (
    .clk(clk), .full_rst_n(full_rst_n), .soft_rst_n(soft_rst_n),
    .sel(sel), .sclk(sclk), .pdata(pdata), .burn_lvl(burn_lvl),
    .loading(loading), .dir_ccw(dir_ccw), .zero_pos(zero_pos),
    .fb_int_en(fb_int_en), .ref_ext_en(ref_ext_en), .clamp_en(clamp_en),
    .out_span(out_span)
  );

  // Bench view of the outputs: rotation sense first, span low bit last.
  function automatic logic [15:0] seen();
    return {dir_ccw, zero_pos, fb_int_en, ref_ext_en, clamp_en, out_span};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enter(input logic pd);
    sel = 1'b0; tick(1);
    pdata = pd; sel = 1'b1; tick(2);
  endtask

  task automatic leave_sel();
    sel = 1'b0; pdata = 1'b0; tick(1);
  endtask

  task automatic send_bit(input logic b);
    pdata = b; sclk = 1'b1; tick(2);
    sclk = 1'b0; tick(2);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) send_bit(w[i]);
  endtask

  task automatic burn(input int pulses);
    burn_lvl = 1'b1; tick(1);
    for (int i = 0; i < pulses; i++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    burn_lvl = 1'b0; tick(1);
  endtask

  task automatic soft_reset();
    soft_rst_n = 1'b0; tick(1);
    soft_rst_n = 1'b1; tick(1);
  endtask

  task automatic full_reset();
    full_rst_n = 1'b0; tick(2);
    full_rst_n = 1'b1; tick(1);
    exp_shadow = '0;
  endtask

  initial begin
    logic [15:0] w1, w2, w3, w4;
    void'($urandom(32'd24681));
    tick(2);
    full_reset();
    check("R1 fields", seen(), 16'h0000);
    check("R1 loading", {15'd0, loading}, 16'h0000);

    enter(1'b0);
    check("R2 no entry loading", {15'd0, loading}, 16'h0000);
    leave_sel();
    send_bits(16'hFFFF, 16);
    check("R2 no entry fields", seen(), 16'h0000);

    w1 = 16'($urandom()) | 16'h0001;
    enter(1'b1);
    check("R11 loading after start", {15'd0, loading}, 16'h0001);
    leave_sel();
    send_bits(w1, 15);
    check("R4 partial word hidden", seen(), 16'h0000);
    check("R11 loading mid word", {15'd0, loading}, 16'h0001);
    send_bit(w1[0]);
    check("R3 word loaded", seen(), w1);
    check("R11 loading end", {15'd0, loading}, 16'h0000);

    send_bits(~w1, 16);
    check("R5 extra clocks ignored", seen(), w1);
    enter(1'b1);
    check("R6 restart ignored loading", {15'd0, loading}, 16'h0000);
    leave_sel();
    send_bits(~w1, 16);
    check("R6 restart ignored fields", seen(), w1);

    soft_reset();
    check("R7 soft reset no burn", seen(), 16'h0000);

    enter(1'b1); leave_sel(); send_bits(16'h8000, 16);
    check("R3 first bit is rotation sense", {15'd0, dir_ccw}, 16'h0001);
    check("R3 rest zero", seen(), 16'h8000);
    soft_reset();
    enter(1'b1); leave_sel(); send_bits(16'h0011, 16);
    check("R3 span low bit last", {14'd0, out_span}, 16'h0001);
    check("R3 feedback bit", {15'd0, fb_int_en}, 16'h0001);
    soft_reset();
    enter(1'b1); leave_sel(); send_bits(16'h4008, 16);
    check("R3 zero msb", {6'd0, zero_pos}, 16'h0200);
    check("R3 reference bit", {15'd0, ref_ext_en}, 16'h0001);
    soft_reset();

    w2 = 16'($urandom());
    enter(1'b1); leave_sel(); send_bits(w2, 16);
    burn(16); exp_shadow = w2;
    check("R8 outputs unchanged by burn", seen(), w2);
    soft_reset();
    check("R8 burned word after soft reset", seen(), w2);

    w3 = ~w2;
    enter(1'b1); leave_sel(); send_bits(w3, 16);
    check("R3 second load", seen(), w3);
    soft_reset();
    check("R7 revert to shadow", seen(), w2);

    w4 = w2 ^ 16'h5A5A;
    enter(1'b1); leave_sel(); send_bits(w4, 16);
    burn(8); burn(8);
    soft_reset();
    check("R9 aborted burn keeps shadow", seen(), w2);

    for (int k = 0; k < 6; k++) begin
      logic [15:0] wr;
      logic do_burn;
      wr = 16'($urandom());
      do_burn = 1'($urandom());
      enter(1'b1); leave_sel(); send_bits(wr, 16);
      check("R3 random load", seen(), wr);
      if (do_burn) begin
        burn(16);
        exp_shadow = wr;
      end
      soft_reset();
      check(do_burn ? "R8 random burn" : "R7 random revert", seen(), exp_shadow);
    end

    full_reset();
    check("R10 full reset fields", seen(), 16'h0000);
    soft_reset();
    check("R10 shadow cleared", seen(), 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule